// File: doc/BRIEF.md
# Two-Wire Addressed Byte Memory Target

This block is a target on a standard-speed two-wire serial bus. It answers to one fixed 7-bit device code and fronts a small byte-wide memory that sits behind a generic synchronous port. A controller sets a 16-bit word pointer by sending two address bytes, low byte first. Through that pointer it can write one byte or a page of bytes, and it can read bytes back one at a time or as a stream.

Written bytes collect in a page buffer. They reach the memory only when a Stop condition closes the write. The Stop starts a timed write cycle. Until that cycle ends the target refuses its own control byte, so a controller can poll with control bytes to learn when the write has finished. The pointer is shared by reads and writes, so a read with no address phase continues from wherever the last access left off.

The bus lines enter through two-flop synchronisers. SDA is driven only as an open-drain enable.

Top module: `i2c_mem_target`

## Requirements
- R1: A control byte whose upper seven bits equal DEV_CODE (default 7'h50, so control bytes 0xA0 for write and 0xA1 for read) is acknowledged on the ninth clock when `busy` is low. Any other code, or any control byte while `busy` is high, gets no acknowledge, and SDA stays released until the next Start.
- R2: In a write transaction the target acknowledges two address bytes. The first is bits 7:0 of the pointer and the second is bits 15:8. `mem_addr` takes the low MEM_AW bits of the pointer.
- R3: Data bytes in a write are acknowledged and held. Memory is written only after a Stop. A repeated Start discards any held bytes and leaves memory unchanged, but the pointer keeps the increments already made.
- R4: A Stop that closes a write holding at least one data byte raises `busy` for WR_CYCLES clocks. While `busy` is high no control byte is acknowledged. Once it falls, a write control byte is acknowledged again.
- R5: A write of N bytes, where N is at most PAGE_BYTES (default 16), puts them at consecutive addresses starting at the pointer value set by the address phase.
- R6: If a write has more than PAGE_BYTES data bytes, the buffer slot index wraps. Slot i keeps the last byte whose position modulo PAGE_BYTES is i, and slots 0..PAGE_BYTES-1 go to the start address plus i.
- R7: The pointer advances by one for every data byte received or sent. A read control byte with no preceding address phase returns the byte at the current pointer.
- R8: A random read is a write control byte, two address bytes, a repeated Start and a read control byte. It returns the byte at the given address.
- R9: During a read, a controller acknowledge brings the next sequential byte. A controller no-acknowledge ends the transfer with SDA released.
- R10: A write transaction that ends with no data bytes leaves `busy` low and only sets the pointer.
- R11: `sda_oe` changes only while the synchronised SCL is low, except on a detected Start or Stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Raw bus clock line |
| sda_in | input | 1 | Raw bus data line |
| sda_oe | output | 1 | 1 pulls SDA low |
| busy | output | 1 | Internal write cycle running |
| mem_addr | output | MEM_AW | Memory address |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_re | output | 1 | Memory read strobe, data valid next clock |
| mem_rdata | input | 8 | Memory read data |

## Verification
The assertions rely on well-formed bus traffic. SDA moves only while SCL is low, apart from deliberate Start and Stop conditions. The controller never drives SDA low during a bit the target owns. They also rely on WR_CYCLES being larger than PAGE_BYTES, so the memory commit always finishes inside the busy window. The bench holds every SDA change 10 clocks after an SCL fall, far beyond the synchroniser delay. It places Starts and Stops only when SCL is high, and draws random addresses, lengths and data only within these framing rules.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CTRL,
        PH_ALO,
        PH_AHI,
        PH_WDAT,
        PH_RDAT,
        PH_RACK
    } phase_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic rise;
        logic fall;
        logic start;
        logic stop;
    } bus_ev_t;

    localparam int PTR_W = 16;

    function automatic logic code_hit(input logic [7:0] ctrl, input logic [6:0] code);
        return ctrl[7:1] == code;
    endfunction

endpackage

// File: rtl/i2cm_bus_sync.sv
module i2cm_bus_sync
    import i2cm_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_in,
    input  logic    sda_in,
    output bus_ev_t ev
);
    logic [2:0] scl_sh, sda_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sh <= 3'b111;
            sda_sh <= 3'b111;
        end else begin
            scl_sh <= {scl_sh[1:0], scl_in};
            sda_sh <= {sda_sh[1:0], sda_in};
        end
    end

    always_comb begin
        ev.scl   = scl_sh[1];
        ev.sda   = sda_sh[1];
        ev.rise  = scl_sh[1] & ~scl_sh[2];
        ev.fall  = ~scl_sh[1] & scl_sh[2];
        ev.start = scl_sh[1] & scl_sh[2] & sda_sh[2] & ~sda_sh[1];
        ev.stop  = scl_sh[1] & scl_sh[2] & ~sda_sh[2] & sda_sh[1];
    end
endmodule

// File: rtl/i2cm_page_buf.sv
module i2cm_page_buf #(
    parameter int PAGE_BYTES = 16,
    parameter int ADDR_W     = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              push,
    input  logic [7:0]        push_data,
    input  logic [ADDR_W-1:0] push_base,
    input  logic              commit_start,
    output logic              pending,
    output logic              commit_we,
    output logic [ADDR_W-1:0] commit_addr,
    output logic [7:0]        commit_data
);
    localparam int IDX_W = $clog2(PAGE_BYTES);
    localparam int CNT_W = $clog2(PAGE_BYTES + 1);

    logic [7:0]        slots [PAGE_BYTES];
    logic [IDX_W-1:0]  wr_idx;
    logic [CNT_W-1:0]  fill;
    logic [CNT_W-1:0]  rd_idx;
    logic [ADDR_W-1:0] base;
    logic              active;

    always_ff @(posedge clk) begin
        if (push && !active) slots[wr_idx] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_idx <= '0;
            fill   <= '0;
            rd_idx <= '0;
            base   <= '0;
            active <= 1'b0;
        end else if (active) begin
            rd_idx <= rd_idx + 1'b1;
            if (rd_idx == fill - 1'b1) begin
                active <= 1'b0;
                fill   <= '0;
                wr_idx <= '0;
            end
        end else if (clear) begin
            fill   <= '0;
            wr_idx <= '0;
        end else if (commit_start && fill != '0) begin
            active <= 1'b1;
            rd_idx <= '0;
        end else if (push) begin
            wr_idx <= (wr_idx == IDX_W'(PAGE_BYTES - 1)) ? '0 : wr_idx + 1'b1;
            if (fill != CNT_W'(PAGE_BYTES)) fill <= fill + 1'b1;
            if (fill == '0) base <= push_base;
        end
    end

    assign pending     = fill != '0;
    assign commit_we   = active;
    assign commit_addr = base + ADDR_W'(rd_idx);
    assign commit_data = slots[rd_idx[IDX_W-1:0]];

    // R5: commit writes walk consecutive addresses
    a_r5_commit_consecutive: assert property (@(posedge clk) disable iff (rst)
        (commit_we && $past(commit_we)) |-> commit_addr == $past(commit_addr) + 1'b1);
endmodule

// File: rtl/i2cm_wr_timer.sv
module i2cm_wr_timer #(
    parameter int WR_CYCLES = 5000
) (
    input  logic clk,
    input  logic rst,
    input  logic kick,
    output logic busy
);
    localparam int CW = $clog2(WR_CYCLES + 1);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (kick)        cnt <= CW'(WR_CYCLES);
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign busy = cnt != '0;

    // R4: a commit request always opens the busy window
    a_r4_kick_busy: assert property (@(posedge clk) disable iff (rst) kick |=> busy);
endmodule

// File: rtl/i2c_mem_target.sv
module i2c_mem_target
    import i2cm_pkg::*;
#(
    parameter logic [6:0] DEV_CODE   = 7'h50,
    parameter int         MEM_AW     = 8,
    parameter int         PAGE_BYTES = 16,
    parameter int         WR_CYCLES  = 5000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    output logic              busy,
    output logic [MEM_AW-1:0] mem_addr,
    output logic              mem_we,
    output logic [7:0]        mem_wdata,
    output logic              mem_re,
    input  logic [7:0]        mem_rdata
);
    bus_ev_t           ev;
    phase_e            phase_q, nxt_q;
    logic [3:0]        bitcnt_q;
    logic [7:0]        shreg_q, addr_lo_q, rd_byte_q;
    logic [PTR_W-1:0]  ptr_q;
    logic              oe_q, ack_drv_q, wr_txn_q, more_q;
    logic              rd_req_q, rd_pend_q;
    logic              push_q;
    logic [7:0]        push_data_q;
    logic [MEM_AW-1:0] push_base_q;
    logic              pending, commit_we, kick, buf_clear;
    logic [MEM_AW-1:0] commit_addr;
    logic [7:0]        commit_data;

    i2cm_bus_sync u_sync (
        .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in), .ev(ev)
    );

    assign kick      = ev.stop & wr_txn_q & pending & ~busy;
    assign buf_clear = ev.start & ~busy;

    i2cm_page_buf #(.PAGE_BYTES(PAGE_BYTES), .ADDR_W(MEM_AW)) u_buf (
        .clk(clk), .rst(rst), .clear(buf_clear),
        .push(push_q), .push_data(push_data_q), .push_base(push_base_q),
        .commit_start(kick), .pending(pending),
        .commit_we(commit_we), .commit_addr(commit_addr), .commit_data(commit_data)
    );

    i2cm_wr_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
        .clk(clk), .rst(rst), .kick(kick), .busy(busy)
    );

    assign sda_oe    = oe_q;
    assign mem_we    = commit_we;
    assign mem_wdata = commit_data;
    assign mem_re    = rd_req_q;
    assign mem_addr  = commit_we ? commit_addr : ptr_q[MEM_AW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q     <= PH_IDLE;
            nxt_q       <= PH_IDLE;
            bitcnt_q    <= '0;
            shreg_q     <= '0;
            addr_lo_q   <= '0;
            rd_byte_q   <= '0;
            ptr_q       <= '0;
            oe_q        <= 1'b0;
            ack_drv_q   <= 1'b0;
            wr_txn_q    <= 1'b0;
            more_q      <= 1'b0;
            rd_req_q    <= 1'b0;
            rd_pend_q   <= 1'b0;
            push_q      <= 1'b0;
            push_data_q <= '0;
            push_base_q <= '0;
        end else begin
            rd_req_q  <= 1'b0;
            push_q    <= 1'b0;
            rd_pend_q <= rd_req_q;
            if (rd_pend_q) rd_byte_q <= mem_rdata;

            if (ev.start) begin
                phase_q   <= PH_CTRL;
                bitcnt_q  <= '0;
                oe_q      <= 1'b0;
                ack_drv_q <= 1'b0;
                wr_txn_q  <= 1'b0;
            end else if (ev.stop) begin
                phase_q   <= PH_IDLE;
                oe_q      <= 1'b0;
                ack_drv_q <= 1'b0;
                wr_txn_q  <= 1'b0;
            end else begin
                unique case (phase_q)
                    PH_CTRL, PH_ALO, PH_AHI, PH_WDAT: begin
                        if (ev.rise && bitcnt_q < 4'd8) begin
                            shreg_q  <= {shreg_q[6:0], ev.sda};
                            bitcnt_q <= bitcnt_q + 1'b1;
                        end
                        if (ev.fall && bitcnt_q == 4'd8) begin
                            if (ack_drv_q) begin
                                ack_drv_q <= 1'b0;
                                phase_q   <= nxt_q;
                                if (nxt_q == PH_RDAT) begin
                                    oe_q     <= ~rd_byte_q[7];
                                    bitcnt_q <= 4'd1;
                                end else begin
                                    oe_q     <= 1'b0;
                                    bitcnt_q <= '0;
                                end
                            end else begin
                                oe_q      <= 1'b1;
                                ack_drv_q <= 1'b1;
                                unique case (phase_q)
                                    PH_CTRL: begin
                                        if (code_hit(shreg_q, DEV_CODE) && !busy) begin
                                            if (shreg_q[0]) begin
                                                nxt_q    <= PH_RDAT;
                                                rd_req_q <= 1'b1;
                                            end else begin
                                                nxt_q    <= PH_ALO;
                                                wr_txn_q <= 1'b1;
                                            end
                                        end else begin
                                            oe_q      <= 1'b0;
                                            ack_drv_q <= 1'b0;
                                            phase_q   <= PH_IDLE;
                                        end
                                    end
                                    PH_ALO: begin
                                        addr_lo_q <= shreg_q;
                                        nxt_q     <= PH_AHI;
                                    end
                                    PH_AHI: begin
                                        ptr_q <= {shreg_q, addr_lo_q};
                                        nxt_q <= PH_WDAT;
                                    end
                                    default: begin
                                        push_q      <= 1'b1;
                                        push_data_q <= shreg_q;
                                        push_base_q <= ptr_q[MEM_AW-1:0];
                                        ptr_q       <= ptr_q + 1'b1;
                                        nxt_q       <= PH_WDAT;
                                    end
                                endcase
                            end
                        end
                    end
                    PH_RDAT: begin
                        if (ev.fall) begin
                            if (bitcnt_q < 4'd8) begin
                                oe_q     <= ~rd_byte_q[3'd7 - bitcnt_q[2:0]];
                                bitcnt_q <= bitcnt_q + 1'b1;
                            end else begin
                                oe_q    <= 1'b0;
                                ptr_q   <= ptr_q + 1'b1;
                                phase_q <= PH_RACK;
                            end
                        end
                    end
                    PH_RACK: begin
                        if (ev.rise) begin
                            more_q   <= ~ev.sda;
                            rd_req_q <= ~ev.sda;
                        end
                        if (ev.fall) begin
                            if (more_q) begin
                                phase_q  <= PH_RDAT;
                                oe_q     <= ~rd_byte_q[7];
                                bitcnt_q <= 4'd1;
                            end else begin
                                phase_q <= PH_IDLE;
                                oe_q    <= 1'b0;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R4: no acknowledge of a control byte while the write cycle runs
    a_r4_no_ack_busy: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_CTRL && busy) |-> !sda_oe);

    // R11: SDA output only moves while SCL is low
    a_r11_sda_still_scl_high: assert property (@(posedge clk) disable iff (rst)
        (ev.scl && $past(ev.scl) && !ev.start && !ev.stop) |-> $stable(sda_oe));

    // R3: memory is written only inside the write cycle after Stop
    a_r3_we_in_busy: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> busy);

    // R9: the controller acknowledge slot is left free
    a_r9_rack_released: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_RACK) |-> !sda_oe);
endmodule

// File: tb/test_i2c_mem_target.sv
module test_i2c_mem_target;
    localparam int WRC = 600;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_oe, busy, mem_we, mem_re;
    logic [7:0] mem_addr, mem_wdata, mem_rdata;
    logic [7:0] dmem [256];
    logic [7:0] expm [256];
    logic [7:0] pb [32];
    logic [15:0] sptr;
    int nchk = 0, nfail = 0;
    bit  done = 0;

    wire sda_bus = sda_m & ~sda_oe;

    always #4 clk = ~clk;

    i2c_mem_target #(.WR_CYCLES(WRC)) i_i2c_mem_target (
        .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_bus),
        .sda_oe(sda_oe), .busy(busy), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_re(mem_re), .mem_rdata(mem_rdata)
    );

    function automatic logic [7:0] seed_val(input int i);
        return 8'(i * 7 + 3);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 256; i++) dmem[i] <= seed_val(i);
            mem_rdata <= '0;
        end else begin
            if (mem_we) dmem[mem_addr] <= mem_wdata;
            if (mem_re) mem_rdata <= dmem[mem_addr];
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(10); scl_m = 1'b1; tick(10);
        sda_m = 1'b0; tick(10); scl_m = 1'b0; tick(10);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(10); scl_m = 1'b1; tick(10);
        sda_m = 1'b1; tick(20);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(10); scl_m = 1'b1; tick(10); scl_m = 1'b0; tick(10);
        end
        sda_m = 1'b1; tick(10); scl_m = 1'b1; tick(5);
        acked = ~sda_bus;
        tick(5); scl_m = 1'b0; tick(10);
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; tick(10); scl_m = 1'b1; tick(5);
            b[i] = sda_bus;
            tick(5); scl_m = 1'b0; tick(10);
        end
        sda_m = ~mack; tick(10); scl_m = 1'b1; tick(10); scl_m = 1'b0; tick(10);
        sda_m = 1'b1;
    endtask

    // R4: acknowledge polling until the write cycle ends
    task automatic poll_idle();
        logic ak;
        ak = 1'b0;
        for (int t = 0; t < 20 && !ak; t++) begin
            bus_start(); send_byte(8'hA0, ak); bus_stop();
        end
        chk("R4 poll ack after write cycle", ak, 1'b1);
        chk("R10 no busy after poll", busy, 1'b0);
    endtask

    task automatic do_write(input logic [15:0] a, input int n);
        logic ak;
        logic [7:0] ent [16];
        bus_start();
        send_byte(8'hA0, ak); chk("R1 write ctrl ack", ak, 1'b1);
        send_byte(a[7:0], ak);  chk("R2 addr lo ack", ak, 1'b1);
        send_byte(a[15:8], ak); chk("R2 addr hi ack", ak, 1'b1);
        for (int k = 0; k < n; k++) begin
            send_byte(pb[k], ak); chk("R3 data ack", ak, 1'b1);
            ent[k % 16] = pb[k];
        end
        bus_stop();
        sptr = a + 16'(n);
        if (n > 0) begin
            tick(3);
            chk("R4 busy after stop", busy, 1'b1);
            for (int i = 0; i < (n < 16 ? n : 16); i++) expm[8'(a + 16'(i))] = ent[i];
            poll_idle();
        end else begin
            tick(3);
            chk("R10 no busy on address-only write", busy, 1'b0);
        end
    endtask

    task automatic do_read(input logic set_addr, input logic [15:0] a, input int n, input string tag);
        logic ak;
        logic [7:0] b;
        bus_start();
        if (set_addr) begin
            send_byte(8'hA0, ak);
            send_byte(a[7:0], ak);
            send_byte(a[15:8], ak);
            bus_start();
            sptr = a;
        end
        send_byte(8'hA1, ak); chk("R8 read ctrl ack", ak, 1'b1);
        for (int k = 0; k < n; k++) begin
            recv_byte(k != n - 1, b);
            chk(tag, b, expm[sptr[7:0]]);
            sptr++;
        end
        bus_stop();
        chk("R9 sda released after read", sda_oe, 1'b0);
    endtask

    initial begin
        logic ak;
        logic [7:0] b;
        void'($urandom(32'd4711));
        for (int i = 0; i < 256; i++) expm[i] = seed_val(i);
        sptr = '0;
        tick(5);
        chk("R1 reset sda_oe", sda_oe, 1'b0);
        chk("R4 reset busy", busy, 1'b0);
        chk("R3 reset mem_we", mem_we, 1'b0);
        rst = 1'b0;
        tick(5);

        // R1: foreign device code is not acknowledged
        bus_start(); send_byte(8'hB0, ak); chk("R1 foreign code nack", ak, 1'b0); bus_stop();

        // R3/R4: single byte write, polling while busy
        bus_start();
        send_byte(8'hA0, ak); send_byte(8'h10, ak); send_byte(8'h00, ak);
        send_byte(8'h5A, ak); chk("R3 byte ack", ak, 1'b1);
        chk("R3 memory untouched before stop", dmem[8'h10], seed_val(16));
        bus_stop();
        tick(3);
        chk("R4 busy raised", busy, 1'b1);
        bus_start(); send_byte(8'hA0, ak); chk("R4 nack while busy", ak, 1'b0); bus_stop();
        expm[8'h10] = 8'h5A;
        poll_idle();
        chk("R3 byte committed", dmem[8'h10], 8'h5A);

        // R8: random read
        do_read(1'b1, 16'h0010, 1, "R8 random read data");

        // R5/R9/R7: short page, sequential read, then current-address read
        for (int k = 0; k < 5; k++) pb[k] = 8'hC0 + 8'(k);
        do_write(16'h0020, 5);
        do_read(1'b1, 16'h0020, 5, "R5 R9 sequential page data");
        do_read(1'b0, 16'h0000, 1, "R7 current address read");

        // R6: page overflow wraps buffer slots
        for (int k = 0; k < 20; k++) pb[k] = 8'h80 + 8'(k);
        do_write(16'h0140, 20);
        chk("R6 wrapped slot 0", dmem[8'h40], 8'h90);
        chk("R6 untouched beyond page", dmem[8'h50], seed_val(8'h50));
        do_read(1'b1, 16'h0140, 21, "R6 overflow readback");

        // R10: address-only write sets the pointer
        do_write(16'h0033, 0);
        do_read(1'b0, 16'h0000, 1, "R10 pointer from address-only write");

        // R3: repeated start discards held data
        bus_start();
        send_byte(8'hA0, ak); send_byte(8'h60, ak); send_byte(8'h00, ak);
        send_byte(8'hEE, ak);
        bus_start();
        sptr = 16'h0061;
        send_byte(8'hA1, ak);
        recv_byte(1'b0, b);
        bus_stop();
        chk("R3 read after abort", b, expm[8'h61]);
        chk("R3 no busy after abort", busy, 1'b0);
        chk("R3 aborted byte not written", dmem[8'h60], seed_val(8'h60));

        // random mix
        for (int it = 0; it < 6; it++) begin
            logic [15:0] wa, ra;
            int n, m;
            wa = 16'($urandom());
            n  = $urandom_range(1, 20);
            for (int k = 0; k < n; k++) pb[k] = 8'($urandom());
            do_write(wa, n);
            ra = ($urandom_range(0, 1) == 1) ? wa : 16'($urandom());
            m  = $urandom_range(1, 4);
            do_read(1'b1, ra, m, "R5 R7 random readback");
        end

        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            nchk++; nfail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end
endmodule